// File: doc/BRIEF.md
# Accumulator Datapath with Carry Rotates and Nibble Exchange

This block is the combinational arithmetic and logic path that sits behind the accumulator of a small 8-bit controller core. Each evaluation takes an operation code, the present accumulator, a second operand byte and the carry flag. It returns the next accumulator value and the next carry. It also returns a secondary byte that carries the value to write back to the operand's home location when an exchange is performed.

The surrounding core fetches the operand, selects the operation and registers the results. This path does not hold state and does not decode addresses. The operations are:

- binary add, with or without the incoming carry
- subtract with borrow
- increment and decrement
- bitwise AND, OR and XOR
- clear and complement
- circular rotates, plain and through carry
- nibble swap, full exchange and low-nibble exchange

Carry is the only flag produced.

The data width is a parameter and must be even. A second parameter chooses between one shared adder and separate arithmetic units.

Top module: `acc_alu`

## Requirements
- R1: Code 0x00 (add) gives acc_out = acc_in + opnd_in modulo 256 and cy_out = bit 8 of the 9-bit sum; cy_in has no effect.
- R2: Code 0x01 (add with carry) gives acc_out = acc_in + opnd_in + cy_in modulo 256, with cy_out = bit 8 of that 9-bit sum.
- R3: Code 0x02 (subtract with borrow) gives acc_out = acc_in - opnd_in - cy_in modulo 256, with cy_out = 1 exactly when opnd_in + cy_in exceeds acc_in.
- R4: Codes 0x03 (increment) and 0x04 (decrement) change acc_in by one, wrapping 0xFF to 0x00 and 0x00 to 0xFF; cy_out equals cy_in.
- R5: Codes 0x05, 0x06 and 0x07 give the bitwise AND, OR and XOR of acc_in and opnd_in respectively; cy_out equals cy_in.
- R6: Code 0x08 gives acc_out = 0x00 and code 0x09 gives the bitwise inverse of acc_in; cy_out equals cy_in for both.
- R7: Code 0x0A rotates acc_in left by one position circularly (bit 7 goes to bit 0), and code 0x0C rotates it right circularly (bit 0 goes to bit 7). For both, cy_out equals cy_in.
- R8: Code 0x0B rotates left through carry: cy_out = acc_in[7] and acc_out[0] = cy_in. Code 0x0D rotates right through carry: cy_out = acc_in[0] and acc_out[7] = cy_in.
- R9: Code 0x0E gives acc_out = {acc_in[3:0], acc_in[7:4]}, with cy_out equal to cy_in.
- R10: Code 0x0F gives acc_out = {acc_in[7:4], opnd_in[3:0]} and aux_out = {opnd_in[7:4], acc_in[3:0]}; cy_out equals cy_in.
- R11: Code 0x10 gives acc_out = opnd_in and aux_out = acc_in, with cy_out equal to cy_in.
- R12: For every code other than 0x0F and 0x10, aux_out equals opnd_in.
- R13: Codes 0x11 to 0x1F give acc_out = acc_in and cy_out = cy_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| acc_in | input | DATA_W | Present accumulator value |
| opnd_in | input | DATA_W | Second operand byte |
| cy_in | input | 1 | Present carry flag |
| acc_out | output | DATA_W | Next accumulator value |
| cy_out | output | 1 | Next carry flag |
| aux_out | output | DATA_W | Byte to write back to the operand location |

## Verification
The checker assumes that the inputs are two-state and settled whenever its combinational checks are evaluated. Under that assumption it relates the outputs only to the same-instant inputs, with no history. The stimulus holds all four inputs constant for a whole clock period and changes them only just after the rising edge. The monitor compares the outputs on the falling edge.

Because every input combination is legal, the stimulus covers all 32 operation codes, including the unassigned ones. It uses directed carry-boundary values together with pseudo-random operand bytes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W = 5;

   localparam logic [OP_W-1:0] OP_ADD  = 5'h00;
   localparam logic [OP_W-1:0] OP_ADDC = 5'h01;
   localparam logic [OP_W-1:0] OP_SUBB = 5'h02;
   localparam logic [OP_W-1:0] OP_INC  = 5'h03;
   localparam logic [OP_W-1:0] OP_DEC  = 5'h04;
   localparam logic [OP_W-1:0] OP_AND  = 5'h05;
   localparam logic [OP_W-1:0] OP_OR   = 5'h06;
   localparam logic [OP_W-1:0] OP_XOR  = 5'h07;
   localparam logic [OP_W-1:0] OP_CLR  = 5'h08;
   localparam logic [OP_W-1:0] OP_CPL  = 5'h09;
   localparam logic [OP_W-1:0] OP_RL   = 5'h0A;
   localparam logic [OP_W-1:0] OP_RLC  = 5'h0B;
   localparam logic [OP_W-1:0] OP_RR   = 5'h0C;
   localparam logic [OP_W-1:0] OP_RRC  = 5'h0D;
   localparam logic [OP_W-1:0] OP_SWAP = 5'h0E;
   localparam logic [OP_W-1:0] OP_XCHD = 5'h0F;
   localparam logic [OP_W-1:0] OP_XCH  = 5'h10;

   typedef enum logic [1:0] {
      CLS_NONE  = 2'd0,
      CLS_ARITH = 2'd1,
      CLS_LOGIC = 2'd2,
      CLS_SHUF  = 2'd3
   } op_class_e;

   function automatic op_class_e classify(input logic [OP_W-1:0] op);
      if (op <= OP_DEC)       return CLS_ARITH;
      else if (op <= OP_CPL)  return CLS_LOGIC;
      else if (op <= OP_XCH)  return CLS_SHUF;
      else                    return CLS_NONE;
   endfunction

endpackage

// File: rtl/acc_arith.sv
module acc_arith
   import acc_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit SHARE_ADDER = 1'b1
) (
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);

   localparam int SUM_W = DATA_W + 1;

   logic keep_c;
   assign keep_c = (op_sel == OP_INC) || (op_sel == OP_DEC);

   generate
      if (SHARE_ADDER) begin : g_shared
         logic [DATA_W-1:0] rhs;
         logic              cin_eff;
         logic              inv_c;
         logic [SUM_W-1:0]  sum;

         always_comb begin
            rhs     = '0;
            cin_eff = 1'b0;
            inv_c   = 1'b0;
            case (op_sel)
               OP_ADD:  rhs = b_in;
               OP_ADDC: begin
                  rhs     = b_in;
                  cin_eff = c_in;
               end
               OP_SUBB: begin
                  rhs     = ~b_in;
                  cin_eff = ~c_in;
                  inv_c   = 1'b1;
               end
               OP_INC:  cin_eff = 1'b1;
               OP_DEC:  rhs = '1;
               default: ;
            endcase
         end

         assign sum   = {1'b0, a_in} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin_eff};
         assign res   = sum[DATA_W-1:0];
         assign c_out = keep_c ? c_in : (sum[DATA_W] ^ inv_c);
      end else begin : g_split
         logic [SUM_W-1:0] add_s;
         logic [SUM_W-1:0] sub_s;
         logic             use_c;

         assign use_c = (op_sel == OP_ADDC) && c_in;
         assign add_s = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, use_c};
         assign sub_s = {1'b0, a_in} - {1'b0, b_in} - {{DATA_W{1'b0}}, c_in};

         always_comb begin
            res   = a_in;
            c_out = c_in;
            case (op_sel)
               OP_ADD, OP_ADDC: begin
                  res   = add_s[DATA_W-1:0];
                  c_out = add_s[DATA_W];
               end
               OP_SUBB: begin
                  res   = sub_s[DATA_W-1:0];
                  c_out = sub_s[DATA_W];
               end
               OP_INC:  res = a_in + 1'b1;
               OP_DEC:  res = a_in - 1'b1;
               default: ;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/acc_logic.sv
module acc_logic
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] res
);

   always_comb begin
      case (op_sel)
         OP_AND:  res = a_in & b_in;
         OP_OR:   res = a_in | b_in;
         OP_XOR:  res = a_in ^ b_in;
         OP_CLR:  res = '0;
         OP_CPL:  res = ~a_in;
         default: res = a_in;
      endcase
   end

endmodule

// File: rtl/acc_shuffle.sv
module acc_shuffle
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out,
   output logic [DATA_W-1:0] aux
);

   localparam int HALF = DATA_W / 2;
   localparam int MSB  = DATA_W - 1;

   always_comb begin
      res   = a_in;
      c_out = c_in;
      aux   = b_in;
      case (op_sel)
         OP_RL:   res = {a_in[MSB-1:0], a_in[MSB]};
         OP_RR:   res = {a_in[0], a_in[MSB:1]};
         OP_RLC: begin
            res   = {a_in[MSB-1:0], c_in};
            c_out = a_in[MSB];
         end
         OP_RRC: begin
            res   = {c_in, a_in[MSB:1]};
            c_out = a_in[0];
         end
         OP_SWAP: res = {a_in[HALF-1:0], a_in[MSB:HALF]};
         OP_XCHD: begin
            res = {a_in[MSB:HALF], b_in[HALF-1:0]};
            aux = {b_in[MSB:HALF], a_in[HALF-1:0]};
         end
         OP_XCH: begin
            res = b_in;
            aux = a_in;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit SHARE_ADDER = 1'b1
) (
   input  logic [4:0]        op_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd_in,
   input  logic              cy_in,
   output logic [DATA_W-1:0] acc_out,
   output logic              cy_out,
   output logic [DATA_W-1:0] aux_out
);

   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("acc_alu: DATA_W must be even and at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] ar_res, lg_res, sh_res, sh_aux;
   logic              ar_c, sh_c;
   op_class_e         cls;

   assign cls = classify(op_sel);

   acc_arith #(.DATA_W(DATA_W), .SHARE_ADDER(SHARE_ADDER)) u_arith (
      .op_sel (op_sel),
      .a_in   (acc_in),
      .b_in   (opnd_in),
      .c_in   (cy_in),
      .res    (ar_res),
      .c_out  (ar_c)
   );

   acc_logic #(.DATA_W(DATA_W)) u_logic (
      .op_sel (op_sel),
      .a_in   (acc_in),
      .b_in   (opnd_in),
      .res    (lg_res)
   );

   acc_shuffle #(.DATA_W(DATA_W)) u_shuf (
      .op_sel (op_sel),
      .a_in   (acc_in),
      .b_in   (opnd_in),
      .c_in   (cy_in),
      .res    (sh_res),
      .c_out  (sh_c),
      .aux    (sh_aux)
   );

   always_comb begin
      acc_out = acc_in;
      cy_out  = cy_in;
      aux_out = opnd_in;
      case (cls)
         CLS_ARITH: begin
            acc_out = ar_res;
            cy_out  = ar_c;
         end
         CLS_LOGIC: acc_out = lg_res;
         CLS_SHUF: begin
            acc_out = sh_res;
            cy_out  = sh_c;
            aux_out = sh_aux;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic [4:0]        op_sel,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] opnd_in,
   input logic              cy_in,
   input logic [DATA_W-1:0] acc_out,
   input logic              cy_out,
   input logic [DATA_W-1:0] aux_out
);

   localparam int HALF = DATA_W / 2;
   localparam int MSB  = DATA_W - 1;

   logic [DATA_W:0] need;
   assign need = {1'b0, opnd_in} + {{DATA_W{1'b0}}, cy_in};

   always_comb begin
      if (op_sel == OP_ADD) begin
         a_r1_add_inverse: assert ((acc_out - opnd_in) == acc_in && cy_out == (acc_out < acc_in))
            else $error("a_r1_add_inverse");
      end
      if (op_sel == OP_ADDC) begin
         a_r2_addc_inverse: assert ((DATA_W'(acc_out - opnd_in - {{MSB{1'b0}}, cy_in})) == acc_in)
            else $error("a_r2_addc_inverse");
      end
      if (op_sel == OP_SUBB) begin
         a_r3_subb_borrow: assert ((DATA_W'(acc_out + opnd_in + {{MSB{1'b0}}, cy_in})) == acc_in
                                   && cy_out == (need > {1'b0, acc_in}))
            else $error("a_r3_subb_borrow");
      end
      if (op_sel == OP_INC || op_sel == OP_DEC) begin
         a_r4_step_keeps_carry: assert (cy_out == cy_in && acc_out != acc_in)
            else $error("a_r4_step_keeps_carry");
      end
      if (op_sel == OP_CLR) begin
         a_r6_clear_zero: assert (acc_out == '0 && cy_out == cy_in)
            else $error("a_r6_clear_zero");
      end
      if (op_sel == OP_RL || op_sel == OP_RR) begin
         a_r7_rot_ones: assert ($countones(acc_out) == $countones(acc_in) && cy_out == cy_in)
            else $error("a_r7_rot_ones");
      end
      if (op_sel == OP_RLC || op_sel == OP_RRC) begin
         a_r8_rot_carry_ones: assert ($countones({cy_out, acc_out}) == $countones({cy_in, acc_in}))
            else $error("a_r8_rot_carry_ones");
      end
      if (op_sel == OP_SWAP) begin
         a_r9_swap_halves: assert (acc_out[HALF-1:0] == acc_in[MSB:HALF] && acc_out[MSB:HALF] == acc_in[HALF-1:0])
            else $error("a_r9_swap_halves");
      end
      if (op_sel == OP_XCHD) begin
         a_r10_xchd_upper_kept: assert (acc_out[MSB:HALF] == acc_in[MSB:HALF] && aux_out[MSB:HALF] == opnd_in[MSB:HALF]
                                        && aux_out[HALF-1:0] == acc_in[HALF-1:0])
            else $error("a_r10_xchd_upper_kept");
      end
      if (op_sel == OP_XCH) begin
         a_r11_xch_cross: assert (acc_out == opnd_in && aux_out == acc_in)
            else $error("a_r11_xch_cross");
      end
      if (op_sel != OP_XCHD && op_sel != OP_XCH) begin
         a_r12_aux_passes: assert (aux_out == opnd_in)
            else $error("a_r12_aux_passes");
      end
      if (op_sel > OP_XCH) begin
         a_r13_unused_holds: assert (acc_out == acc_in && cy_out == cy_in)
            else $error("a_r13_unused_holds");
      end
   end

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

   typedef struct {
      logic [4:0] op;
      logic [7:0] ea;
      logic       ec;
      logic [7:0] ex;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] op_sel = '0;
   logic [7:0] acc_in = '0;
   logic [7:0] opnd_in = '0;
   logic       cy_in = 1'b0;
   logic [7:0] acc_out, aux_out;
   logic       cy_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   item_t q[$];
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   acc_alu u0 (
      .op_sel  (op_sel),
      .acc_in  (acc_in),
      .opnd_in (opnd_in),
      .cy_in   (cy_in),
      .acc_out (acc_out),
      .cy_out  (cy_out),
      .aux_out (aux_out)
   );

   function automatic string tag(input logic [4:0] op);
      case (op)
         5'h00: return "R1";
         5'h01: return "R2";
         5'h02: return "R3";
         5'h03, 5'h04: return "R4";
         5'h05, 5'h06, 5'h07: return "R5";
         5'h08, 5'h09: return "R6";
         5'h0A, 5'h0C: return "R7";
         5'h0B, 5'h0D: return "R8";
         5'h0E: return "R9";
         5'h0F: return "R10";
         5'h10: return "R11";
         default: return "R13";
      endcase
   endfunction

   function automatic item_t model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b, input logic c);
      item_t it;
      int t;
      it.op = op; it.ea = a; it.ec = c; it.ex = b;
      case (op)
         5'h00: begin t = int'(a) + int'(b); it.ea = t[7:0]; it.ec = (t > 255); end
         5'h01: begin t = int'(a) + int'(b) + int'(c); it.ea = t[7:0]; it.ec = (t > 255); end
         5'h02: begin t = int'(a) - int'(b) - int'(c); it.ea = t[7:0]; it.ec = (t < 0); end
         5'h03: it.ea = (a == 8'hFF) ? 8'h00 : a + 8'd1;
         5'h04: it.ea = (a == 8'h00) ? 8'hFF : a - 8'd1;
         5'h05: it.ea = a & b;
         5'h06: it.ea = a | b;
         5'h07: it.ea = a ^ b;
         5'h08: it.ea = 8'h00;
         5'h09: it.ea = ~a;
         5'h0A: it.ea = {a[6:0], a[7]};
         5'h0C: it.ea = {a[0], a[7:1]};
         5'h0B: begin it.ea = {a[6:0], c}; it.ec = a[7]; end
         5'h0D: begin it.ea = {c, a[7:1]}; it.ec = a[0]; end
         5'h0E: it.ea = {a[3:0], a[7:4]};
         5'h0F: begin it.ea = {a[7:4], b[3:0]}; it.ex = {b[7:4], a[3:0]}; end
         5'h10: begin it.ea = b; it.ex = a; end
         default: ;
      endcase
      return it;
   endfunction

   task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b, input logic c);
      @(posedge clk);
      #1;
      op_sel = op; acc_in = a; opnd_in = b; cy_in = c;
      q.push_back(model(op, a, b, c));
   endtask

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         string at;
         it = q.pop_front();
         check(acc_out == it.ea, tag(it.op), "acc", int'(acc_out), int'(it.ea));
         check(cy_out == it.ec, tag(it.op), "carry", int'(cy_out), int'(it.ec));
         at = (it.op == 5'h0F || it.op == 5'h10) ? tag(it.op) : "R12";
         check(aux_out == it.ex, at, "aux", int'(aux_out), int'(it.ex));
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // idle state under reset: add of zeros gives zero, no carry (R1)
      check(acc_out == 8'h00 && cy_out == 1'b0, "R1", "reset idle", int'({cy_out, acc_out}), 0);
      rst_n = 1'b1;

      // R1: carry boundary, incoming carry ignored
      drive(5'h00, 8'hFF, 8'h01, 1'b1);
      drive(5'h00, 8'h7F, 8'h80, 1'b1);
      // R2: carry-in pushes over the top
      drive(5'h01, 8'hFF, 8'h00, 1'b1);
      drive(5'h01, 8'h80, 8'h80, 1'b0);
      // R3: borrow from carry alone, and equal operands
      drive(5'h02, 8'h00, 8'h00, 1'b1);
      drive(5'h02, 8'h05, 8'h05, 1'b0);
      drive(5'h02, 8'h05, 8'h04, 1'b1);
      // R4: wrap both ways
      drive(5'h03, 8'hFF, 8'h00, 1'b1);
      drive(5'h04, 8'h00, 8'h00, 1'b0);
      // R6
      drive(5'h08, 8'hA5, 8'h3C, 1'b1);
      drive(5'h09, 8'hA5, 8'h3C, 1'b0);
      // R8: carry enters and leaves
      drive(5'h0B, 8'h80, 8'h00, 1'b0);
      drive(5'h0D, 8'h01, 8'h00, 1'b0);
      drive(5'h0D, 8'h00, 8'h00, 1'b1);
      // R10 / R11
      drive(5'h0F, 8'h12, 8'hAB, 1'b0);
      drive(5'h10, 8'h12, 8'hAB, 1'b1);
      // R13: unused code
      drive(5'h1F, 8'h5A, 8'hC3, 1'b1);

      for (int n = 0; n < 40; n++) begin
         for (int op = 0; op < 32; op++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(5'(op), lfsr[7:0], lfsr[15:8], lfsr[3]);
         end
      end

      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule